// File: doc/BRIEF.md
# Windowed Error Record Address Access

This block keeps one 64-bit fault address register for each of a fixed number of error records. Software does not reach these registers directly. It first loads a select register with a record index. All later accesses then go through one window, and that window always points at the chosen record. The window has three views, picked by a 2-bit view code. One view is a full 64-bit view. The other two are 32-bit half views: one reaches the lower word and one reaches the upper word of the same storage.

Each access is checked against a record count supplied from outside. If the count is zero, or the index is not below the count, or the index is not below the number of stored records, the selection is invalid. An invalid read returns zero and an invalid write changes nothing. One cycle after an invalid access, a single-cycle flag is raised.

Permission to access is decided elsewhere and arrives on a grant input. A build-time switch can leave the whole window out. When the window is left out, every access is reported as undefined. The reserved view code is also reported as undefined.

Top module: `err_addr_window`

## Requirements
- R1: A synchronous reset clears the select register, every record and the invalid flag to zero.
- R2: When `sel_wr` is high at a clock edge, `sel_wdata` is loaded into the select register, and `sel_q` shows the new value from that edge on.
- R3: View code 2'b00 is the full view. A granted, valid write replaces the whole selected record at the next clock edge. A granted, valid read returns the whole record on `rd_data` in the same cycle.
- R4: View code 2'b01 is the lower-word view, covering bits [31:0]. A write changes only bits [31:0], taken from `acc_wdata[31:0]`. A read returns bits [31:0] in `rd_data[31:0]`, with `rd_data[63:32]` at zero.
- R5: View code 2'b10 is the upper-word view, covering bits [63:32]. A write changes only bits [63:32], taken from `acc_wdata[31:0]`. A read returns bits [63:32] in `rd_data[31:0]`, with `rd_data[63:32]` at zero.
- R6: A selection is invalid when `rec_count` is zero, when `sel_q` is at least `rec_count`, or when `sel_q` is at least NREC. On an invalid selection a read gives zero and a write leaves every record unchanged.
- R7: After each granted, defined access with an invalid selection, `inval_o` is high for exactly the next cycle. A valid access never raises it.
- R8: When `acc_grant` is low, a write changes nothing, a read gives zero and `inval_o` stays low.
- R9: `undef_o` is high in the same cycle as any request that uses view code 2'b11, and in any cycle with a request when the block is built with FEAT_EN=0. Such a request reads zero, writes nothing and does not raise `inval_o`.
- R10: Records are independent: a write reaches only the selected record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rec_count | input | CNT_W | Number of implemented records |
| sel_wr | input | 1 | Load strobe for the select register |
| sel_wdata | input | SEL_W | New record index |
| acc_req | input | 1 | Window access request |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_grant | input | 1 | Permission from the external checker |
| acc_view | input | 2 | View code: 00 full, 01 lower word, 10 upper word, 11 reserved |
| acc_wdata | input | 64 | Write data; the half views use bits [31:0] |
| rd_data | output | 64 | Read data from the window |
| sel_q | output | SEL_W | Current record index |
| inval_o | output | 1 | One-cycle pulse after an invalid access |
| undef_o | output | 1 | Request not defined (window absent or reserved view) |

## Verification
The assertions assume three things about the inputs. `rec_count` and the select index change only between accesses, never while a request is in flight. Requests stay low during reset. `acc_wr`, `acc_view` and `acc_grant` are meaningful only while `acc_req` is high. The stimulus changes every input only at the falling edge and clears the request before it changes the select register or the count. This way each invalid-pulse check refers to one known request. Invalid selections are produced in three ways: a count of zero, an index at or above the count, and an index beyond the stored records while the count is larger than that.

// File: rtl/ea_pkg.sv
package ea_pkg;
  localparam int REC_W  = 64;
  localparam int HALF_W = 32;

  typedef enum logic [1:0] {
    VIEW_FULL = 2'b00,
    VIEW_LO   = 2'b01,
    VIEW_HI   = 2'b10,
    VIEW_RSVD = 2'b11
  } view_e;

  // index is usable only if below both the configured count and the storage size
  function automatic logic sel_in_range(input logic [31:0] sel,
                                        input logic [31:0] cnt,
                                        input logic [31:0] nrec);
    return (cnt != 32'd0) && (sel < cnt) && (sel < nrec);
  endfunction

  // new record value after a write through the given view
  function automatic logic [REC_W-1:0] merge_write(input logic [REC_W-1:0] old,
                                                   input logic [REC_W-1:0] wd,
                                                   input view_e view);
    case (view)
      VIEW_LO: return {old[REC_W-1:HALF_W], wd[HALF_W-1:0]};
      VIEW_HI: return {wd[HALF_W-1:0], old[HALF_W-1:0]};
      default: return wd;
    endcase
  endfunction

  // data presented on the window for a read through the given view
  function automatic logic [REC_W-1:0] extract_read(input logic [REC_W-1:0] rec,
                                                    input view_e view);
    case (view)
      VIEW_LO: return {{HALF_W{1'b0}}, rec[HALF_W-1:0]};
      VIEW_HI: return {{HALF_W{1'b0}}, rec[REC_W-1:HALF_W]};
      default: return rec;
    endcase
  endfunction
endpackage

// File: rtl/ea_sel_reg.sv
module ea_sel_reg #(
  parameter int SEL_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld,
  input  logic [SEL_W-1:0] d,
  output logic [SEL_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (ld) q <= d;
  end
endmodule

// File: rtl/ea_rec_bank.sv
module ea_rec_bank #(
  parameter int NREC  = 4,
  parameter int IDX_W = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   we,
  input  logic [IDX_W-1:0]       idx,
  input  logic [ea_pkg::REC_W-1:0] wdata,
  output logic [ea_pkg::REC_W-1:0] rdata
);
  logic [ea_pkg::REC_W-1:0] recs [NREC];

  for (genvar g = 0; g < NREC; g++) begin : g_rec
    always_ff @(posedge clk) begin
      if (rst)                              recs[g] <= '0;
      else if (we && (idx == IDX_W'(g)))    recs[g] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    if (32'(idx) < NREC) rdata = recs[idx];
  end
endmodule

// File: rtl/ea_access_ctl.sv
module ea_access_ctl #(
  parameter int  NREC    = 4,
  parameter int  CNT_W   = 16,
  parameter int  SEL_W   = 16,
  parameter bit  FEAT_EN = 1'b1
) (
  input  logic             acc_req,
  input  logic             acc_wr,
  input  logic             acc_grant,
  input  ea_pkg::view_e    view,
  input  logic [SEL_W-1:0] sel,
  input  logic [CNT_W-1:0] cnt,
  output logic             acc_ok,
  output logic             bank_we,
  output logic             inval_d,
  output logic             undef
);
  logic in_range, defined, live;

  always_comb begin
    in_range = ea_pkg::sel_in_range(32'(sel), 32'(cnt), 32'(NREC));
    defined  = FEAT_EN && (view != ea_pkg::VIEW_RSVD);
    undef    = acc_req && !defined;
    live     = acc_req && acc_grant && defined;
    acc_ok   = live && in_range;
    bank_we  = acc_ok && acc_wr;
    inval_d  = live && !in_range;
  end
endmodule

// File: rtl/err_addr_window.sv
module err_addr_window #(
  parameter int NREC    = 4,
  parameter int CNT_W   = 16,
  parameter int SEL_W   = 16,
  parameter bit FEAT_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] rec_count,
  input  logic             sel_wr,
  input  logic [SEL_W-1:0] sel_wdata,
  input  logic             acc_req,
  input  logic             acc_wr,
  input  logic             acc_grant,
  input  logic [1:0]       acc_view,
  input  logic [63:0]      acc_wdata,
  output logic [63:0]      rd_data,
  output logic [SEL_W-1:0] sel_q,
  output logic             inval_o,
  output logic             undef_o
);
  localparam int IDX_W = (NREC > 1) ? $clog2(NREC) : 1;

  ea_pkg::view_e   view;
  logic [IDX_W-1:0] idx;
  logic             acc_ok, bank_we, inval_d;
  logic [63:0]      rec_rd, rec_wd;

  assign view = ea_pkg::view_e'(acc_view);
  assign idx  = sel_q[IDX_W-1:0];

  ea_sel_reg #(.SEL_W(SEL_W)) u_sel (
    .clk(clk), .rst(rst), .ld(sel_wr), .d(sel_wdata), .q(sel_q)
  );

  ea_access_ctl #(.NREC(NREC), .CNT_W(CNT_W), .SEL_W(SEL_W), .FEAT_EN(FEAT_EN)) u_ctl (
    .acc_req(acc_req), .acc_wr(acc_wr), .acc_grant(acc_grant), .view(view),
    .sel(sel_q), .cnt(rec_count), .acc_ok(acc_ok), .bank_we(bank_we),
    .inval_d(inval_d), .undef(undef_o)
  );

  assign rec_wd = ea_pkg::merge_write(rec_rd, acc_wdata, view);

  ea_rec_bank #(.NREC(NREC), .IDX_W(IDX_W)) u_bank (
    .clk(clk), .rst(rst), .we(bank_we), .idx(idx), .wdata(rec_wd), .rdata(rec_rd)
  );

  assign rd_data = acc_ok ? ea_pkg::extract_read(rec_rd, view) : '0;

  always_ff @(posedge clk) begin
    if (rst) inval_o <= 1'b0;
    else     inval_o <= inval_d;
  end
endmodule

// File: rtl/ea_window_chk.sv
module ea_window_chk #(
  parameter int NREC    = 4,
  parameter int CNT_W   = 16,
  parameter int SEL_W   = 16,
  parameter bit FEAT_EN = 1'b1
) (
  input logic             clk,
  input logic             rst,
  input logic [CNT_W-1:0] rec_count,
  input logic             acc_req,
  input logic             acc_grant,
  input logic [1:0]       acc_view,
  input logic [SEL_W-1:0] sel_q,
  input logic [63:0]      rd_data,
  input logic             inval_o,
  input logic             undef_o,
  input logic             bank_we
);
  logic chk_ok, chk_def, chk_bad_req;
  assign chk_ok  = (rec_count != '0) && (32'(sel_q) < 32'(rec_count)) && (32'(sel_q) < NREC);
  assign chk_def = FEAT_EN && (acc_view != 2'b11);
  assign chk_bad_req = acc_req && acc_grant && chk_def && !chk_ok;

  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (sel_q == '0 && !inval_o)); // R1
  AST_BAD_SEL_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (acc_req && !chk_ok) |-> (rd_data == '0)); // R6
  AST_BAD_SEL_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (acc_req && !chk_ok) |-> !bank_we); // R6
  AST_INVAL_PULSE: assert property (@(posedge clk) disable iff (rst)
    inval_o == $past(chk_bad_req)); // R7
  AST_NO_GRANT_QUIET: assert property (@(posedge clk) disable iff (rst)
    (acc_req && !acc_grant) |-> (!bank_we && rd_data == '0)); // R8
  AST_RSVD_UNDEF: assert property (@(posedge clk) disable iff (rst)
    (acc_req && acc_view == 2'b11) |-> (undef_o && !bank_we)); // R9
endmodule

bind err_addr_window ea_window_chk #(
  .NREC(NREC), .CNT_W(CNT_W), .SEL_W(SEL_W), .FEAT_EN(FEAT_EN)
) u_chk (
  .clk(clk), .rst(rst), .rec_count(rec_count), .acc_req(acc_req),
  .acc_grant(acc_grant), .acc_view(acc_view), .sel_q(sel_q), .rd_data(rd_data),
  .inval_o(inval_o), .undef_o(undef_o), .bank_we(bank_we)
);

// File: tb/err_addr_window_bench.sv
module err_addr_window_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] rec_count = 16'd4;
  logic        sel_wr = 1'b0;
  logic [15:0] sel_wdata = '0;
  logic        acc_req = 1'b0, acc_wr = 1'b0, acc_grant = 1'b0;
  logic [1:0]  acc_view = 2'b00;
  logic [63:0] acc_wdata = '0;
  logic [63:0] rd_data, rd_off;
  logic [15:0] sel_q, sel_off;
  logic        inval_o, undef_o, inval_off, undef_off;

  always #5 clk = ~clk;

  err_addr_window u_err_addr_window (
    .clk(clk), .rst(rst), .rec_count(rec_count), .sel_wr(sel_wr), .sel_wdata(sel_wdata),
    .acc_req(acc_req), .acc_wr(acc_wr), .acc_grant(acc_grant), .acc_view(acc_view),
    .acc_wdata(acc_wdata), .rd_data(rd_data), .sel_q(sel_q), .inval_o(inval_o), .undef_o(undef_o)
  );

  err_addr_window #(.FEAT_EN(1'b0)) u_err_addr_window_off (
    .clk(clk), .rst(rst), .rec_count(rec_count), .sel_wr(sel_wr), .sel_wdata(sel_wdata),
    .acc_req(acc_req), .acc_wr(acc_wr), .acc_grant(acc_grant), .acc_view(acc_view),
    .acc_wdata(acc_wdata), .rd_data(rd_off), .sel_q(sel_off), .inval_o(inval_off), .undef_o(undef_off)
  );

  typedef struct { string tag; int sig; logic [63:0] exp; } item_t;
  item_t q[$];
  event  sample_ev;
  int    checks = 0, failures = 0;
  bit    done = 1'b0;
  logic [63:0] m [4];

  localparam logic [63:0] A = 64'h0123_4567_89AB_CDEF;
  localparam logic [63:0] B = 64'hFEDC_BA98_7654_3210;
  localparam logic [63:0] C = 64'h5555_AAAA_5555_AAAA;

  // monitor: pops expected items and compares with the live outputs
  initial begin
    forever begin
      @(sample_ev);
      while (q.size() > 0) begin
        item_t it;
        logic [63:0] act;
        it = q.pop_front();
        case (it.sig)
          0: act = rd_data;
          1: act = {48'b0, sel_q};
          2: act = {63'b0, inval_o};
          3: act = {63'b0, undef_o};
          4: act = rd_off;
          default: act = {63'b0, undef_off};
        endcase
        checks++;
        if (act !== it.exp) begin
          failures++;
          $display("FAIL %s sig=%0d actual=%h expected=%h", it.tag, it.sig, act, it.exp);
        end
      end
    end
  end

  task automatic expect_v(input string tag, input int sig, input logic [63:0] e);
    item_t it;
    it.tag = tag; it.sig = sig; it.exp = e;
    q.push_back(it);
    -> sample_ev;
    wait (q.size() == 0);
  endtask

  task automatic go(input logic [1:0] view, input logic wr, input logic gnt, input logic [63:0] d);
    @(negedge clk);
    acc_req = 1'b1; acc_wr = wr; acc_grant = gnt; acc_view = view; acc_wdata = d;
    #1;
  endtask

  task automatic stop_acc;
    @(negedge clk);
    acc_req = 1'b0; acc_wr = 1'b0; acc_grant = 1'b0;
    #1;
  endtask

  task automatic set_sel(input logic [15:0] v);
    @(negedge clk); sel_wr = 1'b1; sel_wdata = v;
    @(negedge clk); sel_wr = 1'b0;
    #1;
  endtask

  task automatic rd_check(input string tag, input logic [1:0] view, input logic [63:0] e);
    go(view, 1'b0, 1'b1, '0);
    expect_v(tag, 0, e);
    stop_acc;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) m[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    expect_v("R1", 1, 64'd0);
    expect_v("R1", 2, 64'd0);
    rd_check("R1", 2'b00, 64'd0);

    // full view write and read
    go(2'b00, 1'b1, 1'b1, A); stop_acc; m[0] = A;
    expect_v("R7", 2, 64'd0);
    rd_check("R3", 2'b00, m[0]);

    set_sel(16'd2);
    expect_v("R2", 1, 64'd2);
    go(2'b00, 1'b1, 1'b1, B); stop_acc; m[2] = B;
    rd_check("R3", 2'b00, m[2]);
    set_sel(16'd0);
    rd_check("R10", 2'b00, m[0]);

    // lower-word alias
    go(2'b01, 1'b1, 1'b1, 64'hDEAD_BEEF_1111_2222); stop_acc;
    m[0][31:0] = 32'h1111_2222;
    rd_check("R4", 2'b00, m[0]);
    rd_check("R4", 2'b01, {32'b0, m[0][31:0]});

    // upper-word alias
    go(2'b10, 1'b1, 1'b1, 64'h0000_0000_3333_4444); stop_acc;
    m[0][63:32] = 32'h3333_4444;
    rd_check("R5", 2'b10, {32'b0, m[0][63:32]});
    rd_check("R5", 2'b00, m[0]);

    // index at or above count
    set_sel(16'd5);
    go(2'b00, 1'b0, 1'b1, '0);
    expect_v("R6", 0, 64'd0);
    stop_acc;
    expect_v("R7", 2, 64'd1);
    @(negedge clk); #1;
    expect_v("R7", 2, 64'd0);
    go(2'b00, 1'b1, 1'b1, C); stop_acc;
    expect_v("R7", 2, 64'd1);

    rec_count = 16'd2;
    set_sel(16'd3);
    go(2'b00, 1'b1, 1'b1, C); stop_acc;
    rec_count = 16'd4;
    rd_check("R6", 2'b00, m[3]);

    // zero count
    rec_count = 16'd0;
    set_sel(16'd0);
    go(2'b00, 1'b0, 1'b1, '0);
    expect_v("R6", 0, 64'd0);
    go(2'b00, 1'b1, 1'b1, C); stop_acc;
    rec_count = 16'd4;
    rd_check("R6", 2'b00, m[0]);

    // count larger than storage
    rec_count = 16'd8;
    set_sel(16'd6);
    go(2'b00, 1'b0, 1'b1, '0);
    expect_v("R6", 0, 64'd0);
    stop_acc;
    expect_v("R7", 2, 64'd1);
    rec_count = 16'd4;

    // no grant
    set_sel(16'd2);
    go(2'b00, 1'b1, 1'b0, C);
    expect_v("R8", 0, 64'd0);
    stop_acc;
    expect_v("R8", 2, 64'd0);
    go(2'b00, 1'b0, 1'b0, '0);
    expect_v("R8", 0, 64'd0);
    stop_acc;
    rd_check("R8", 2'b00, m[2]);

    // reserved view and window left out
    go(2'b11, 1'b1, 1'b1, C);
    expect_v("R9", 3, 64'd1);
    expect_v("R9", 0, 64'd0);
    expect_v("R9", 5, 64'd1);
    stop_acc;
    expect_v("R9", 3, 64'd0);
    expect_v("R9", 2, 64'd0);
    go(2'b00, 1'b0, 1'b1, '0);
    expect_v("R9", 0, m[2]);
    expect_v("R9", 3, 64'd0);
    expect_v("R9", 5, 64'd1);
    expect_v("R9", 4, 64'd0);
    stop_acc;

    // independence of records
    set_sel(16'd1);
    go(2'b00, 1'b1, 1'b1, C); stop_acc; m[1] = C;
    rd_check("R10", 2'b00, m[1]);
    set_sel(16'd2);
    rd_check("R10", 2'b00, m[2]);
    set_sel(16'd0);
    rd_check("R10", 2'b00, m[0]);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule